// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps time of day and calendar date. Every field is held in packed BCD: seconds, minutes, hours, date, month, two-digit year, century and day of week. A prescaler counts enable pulses from a 32.768 kHz source. Each time it wraps it produces a one-second tick, and that tick advances the time by one second. Carries ripple through minutes, hours, date, month, year and century. The date rollover follows the length of the current month. February has 29 days in every year whose two-digit value is divisible by four.

An external controller sets the time through a parallel load port. The port carries an 8-byte image, a per-byte enable and a strobe. The current time is always visible as an 8-byte snapshot. The hour byte chooses the hour format: it counts either 00 to 23, or 1 to 12 with a PM flag. After power comes back from a total loss, a fail flag keeps the counter frozen. The first write of any clock byte clears the flag.

The image packs one field per byte: byte 0 seconds, byte 1 minutes, byte 2 hours, byte 3 date, byte 4 month, byte 5 year, byte 6 day of week (bits 2:0), byte 7 century.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the snapshot holds 00:00:00 in 24-hour mode (hour byte 0x80), date 01, month 01, year 00, day of week 0 and century 0x20, and the fail flag is 1.
- R2: A tick comes once per 2^PRESC_W enable pulses. A load with any byte enabled clears the prescaler, so the first increment after a load comes a full 2^PRESC_W pulses later. `tick_o` is high in the cycle before the edge that increments the time.
- R3: Seconds and minutes count 00 to 59 in BCD. 59 wraps to 00 and carries into the next field.
- R4: When hour bit 7 is 1, hours count 0x00 to 0x23, and 23 wraps to 00 while advancing the date.
- R5: When hour bit 7 is 0, hours follow 12, 1, ..., 11 in bits 4:0, and bit 5 is the PM flag (1 means PM). The flag toggles on the step from 11 to 12. The date advances only on the step from 11 PM to 12 AM.
- R6: The date wraps to 01 after day 31 of months 1, 3, 5, 7, 8, 10 and 12, and after day 30 of months 4, 6, 9 and 11. February wraps after day 29 when the year is divisible by 4, which includes year 00, and after day 28 otherwise. Month 12 wraps to 01 and advances the year.
- R7: The day of week (byte 6, bits 2:0) steps 0 to 6 and back to 0 on every date change. A loaded value of 7 is stored as 0.
- R8: The year wraps from 0x99 to 0x00 and then moves the century from 0x19 to 0x20. Loading the century byte stores 0x19 only for 0x19, and 0x20 for any other value.
- R9: While the fail flag is 1 the time does not advance. A load with any byte enabled clears the flag.
- R10: A load writes only the enabled bytes. A load with no byte enabled changes nothing, not even the prescaler. Bits that no field uses are stored as 0: bit 7 of seconds, minutes and year-free fields, bit 6 of hours, bits 7:6 of the date, bits 7:5 of the month and bits 7:3 of the day of week.
- R11: When a load and a tick fall on the same edge, the load wins and no increment is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_en | input | 1 | One pulse per 32.768 kHz period |
| ld_stb | input | 1 | Load strobe |
| ld_be | input | 8 | Per-byte load enable |
| ld_img | input | 64 | Time image to load |
| snap | output | 64 | Current time image |
| fail | output | 1 | Counting frozen after total power loss |
| tick_o | output | 1 | One-second tick |

## Verification
The bench loads boundary images and then counts off one or two ticks. The first kind is a single image that sits on the last second of a century, which forces every carry on one edge at once. Other images sit just before the end of 28-, 29-, 30- and 31-day months and before the four 12-hour transitions. These separate a correct month-length and leap-year table from one that is shifted, and tell apart the AM/PM toggle point from the point where the date advances. A second group of patterns places loads against the prescaler phase: on the tick edge, with no byte enabled, and one byte at a time. These show whether a load resets the phase, whether it wins over a tick, and whether only the enabled bytes change.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned NUM_BYTES = 8;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] dow;
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_img_t;

  localparam rtc_img_t RTC_RESET_IMG = '{
    cent:  8'h20, dow:   8'h00, year:  8'h00, month: 8'h01,
    date:  8'h01, hour:  8'h80, min:   8'h00, sec:   8'h00
  };

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] yr);
    logic [6:0] yb;
    logic [7:0] d;
    yb = bcd_to_bin(yr);
    case (mon)
      8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
      8'h02:                      d = (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      default:                    d = 8'h31;
    endcase
    return d;
  endfunction

  // Forces unused bits to zero and keeps fields inside their legal codes.
  function automatic logic [7:0] sanitize_byte(input int unsigned idx,
                                               input logic [7:0] b);
    logic [7:0] r;
    case (idx)
      0, 1:    r = b & 8'h7F;
      2:       r = {b[7], 1'b0, b[5:0]};
      3:       r = b & 8'h3F;
      4:       r = b & 8'h1F;
      6:       r = (b[2:0] == 3'd7) ? 8'h00 : {5'd0, b[2:0]};
      7:       r = (b == 8'h19) ? 8'h19 : 8'h20;
      default: r = b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRESC_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  logic [PRESC_W-1:0] cnt_q;
  logic [PRESC_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = en && (&cnt_q) && !clr;
endmodule

// File: rtl/rtc_cal_next.sv
module rtc_cal_next
  import rtc_pkg::*;
(
  input  rtc_img_t cur,
  output rtc_img_t nxt
);
  logic       c_min, c_hour, c_day, c_mon, c_year;
  logic [5:0] hv;
  logic       pm;

  always_comb begin
    nxt    = cur;
    c_hour = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_year = 1'b0;
    hv     = '0;
    pm     = 1'b0;

    // seconds
    c_min = (cur.sec == 8'h59);
    nxt.sec = c_min ? 8'h00 : bcd_inc(cur.sec);

    // minutes
    if (c_min) begin
      c_hour  = (cur.min == 8'h59);
      nxt.min = c_hour ? 8'h00 : bcd_inc(cur.min);
    end

    // hours
    if (c_hour) begin
      if (cur.hour[7]) begin
        hv = cur.hour[5:0];
        if (hv == 6'h23) begin
          hv    = 6'h00;
          c_day = 1'b1;
        end else begin
          hv = 6'(bcd_inc({2'b00, hv}));
        end
        nxt.hour = {2'b10, hv};
      end else begin
        pm = cur.hour[5];
        hv = {1'b0, cur.hour[4:0]};
        if (hv == 6'h12) begin
          hv = 6'h01;
        end else if (hv == 6'h11) begin
          hv    = 6'h12;
          c_day = pm;
          pm    = ~pm;
        end else begin
          hv = 6'(bcd_inc({2'b00, hv}));
        end
        nxt.hour = {2'b00, pm, hv[4:0]};
      end
    end

    // date and day of week
    if (c_day) begin
      c_mon    = (cur.date == month_last_day(cur.month, cur.year));
      nxt.date = c_mon ? 8'h01 : bcd_inc(cur.date);
      nxt.dow  = (cur.dow[2:0] == 3'd6) ? 8'h00 : {5'd0, cur.dow[2:0] + 3'd1};
    end

    // month
    if (c_mon) begin
      c_year    = (cur.month == 8'h12);
      nxt.month = c_year ? 8'h01 : bcd_inc(cur.month);
    end

    // year and century
    if (c_year) begin
      if (cur.year == 8'h99) begin
        nxt.year = 8'h00;
        nxt.cent = 8'h20;
      end else begin
        nxt.year = bcd_inc(cur.year);
      end
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int unsigned PRESC_W = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_en,
  input  logic        ld_stb,
  input  logic [7:0]  ld_be,
  input  logic [63:0] ld_img,
  output logic [63:0] snap,
  output logic        fail,
  output logic        tick_o
);
  localparam int unsigned IMG_W = 8 * NUM_BYTES;

  logic             rst_i_n;
  logic             load_any;
  logic             tick;
  rtc_img_t         time_q;
  rtc_img_t         time_step;
  logic [IMG_W-1:0] time_d;
  logic             fail_q;
  logic             fail_d;

  rtc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign load_any = ld_stb && (|ld_be);

  rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_i_n),
    .en    (osc_en),
    .clr   (load_any),
    .tick  (tick)
  );

  rtc_cal_next u_next (
    .cur (time_q),
    .nxt (time_step)
  );

  always_comb begin
    time_d = time_q;
    fail_d = fail_q;
    if (load_any) begin
      for (int unsigned i = 0; i < NUM_BYTES; i++) begin
        if (ld_be[i]) time_d[8*i +: 8] = sanitize_byte(i, ld_img[8*i +: 8]);
      end
      fail_d = 1'b0;
    end else if (tick && !fail_q) begin
      time_d = time_step;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      time_q <= RTC_RESET_IMG;
      fail_q <= 1'b1;
    end else begin
      time_q <= time_d;
      fail_q <= fail_d;
    end
  end

  assign snap   = time_q;
  assign fail   = fail_q;
  assign tick_o = tick;
endmodule

// File: rtl/rtc_calendar_checks.sv
module rtc_calendar_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        ld_stb,
  input logic [7:0]  ld_be,
  input logic [63:0] ld_img,
  input logic [63:0] snap,
  input logic        fail,
  input logic        tick_o
);
  a_r8_century_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (snap[63:56] == 8'h19) || (snap[63:56] == 8'h20));

  a_r7_dow_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (snap[55:51] == 5'd0) && (snap[50:48] <= 3'd6));

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(ld_stb && (|ld_be))) |=> $stable(snap));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && (|ld_be)) |=> !fail);

  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !ld_stb && !fail && snap[7:0] == 8'h59) |=> (snap[7:0] == 8'h00));

  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && ld_be[0]) |=> (snap[7:0] == ($past(ld_img[7:0]) & 8'h7F)));

  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

bind rtc_calendar rtc_calendar_checks u_checks (
  .clk    (clk),
  .rst_n  (rst_n),
  .ld_stb (ld_stb),
  .ld_be  (ld_be),
  .ld_img (ld_img),
  .snap   (snap),
  .fail   (fail),
  .tick_o (tick_o)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW         = 2;
  localparam int TPS        = 1 << PW;

  logic        clk;
  logic        rst_n;
  logic        osc_en;
  logic        ld_stb;
  logic [7:0]  ld_be;
  logic [63:0] ld_img;
  logic [63:0] snap;
  logic        fail;
  logic        tick_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  rtc_calendar #(.PRESC_W(PW)) u_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .ld_stb(ld_stb),
    .ld_be(ld_be), .ld_img(ld_img), .snap(snap), .fail(fail), .tick_o(tick_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] mk(input logic [7:0] s, mi, h, d, mo, y,
                                     input logic [2:0] w, input logic [7:0] c);
    return {c, 5'd0, w, y, mo, d, h, mi, s};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Called at a negedge; the load happens on the following posedge.
  task automatic do_load(input logic [7:0] be, input logic [63:0] img);
    ld_stb = 1'b1; ld_be = be; ld_img = img;
    @(negedge clk);
    ld_stb = 1'b0; ld_be = '0; ld_img = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_sec(input int n);
    wait_cyc(n * TPS);
  endtask

  task automatic t_reset_and_fail;
    chk("R1 reset image", snap, mk(8'h00,8'h00,8'h80,8'h01,8'h01,8'h00,3'd0,8'h20));
    chk("R1 fail set", {63'd0, fail}, 64'd1);
    wait_cyc(3 * TPS);
    chk("R9 frozen while fail", snap, mk(8'h00,8'h00,8'h80,8'h01,8'h01,8'h00,3'd0,8'h20));
    do_load(8'h01, 64'h30);
    chk("R9 fail cleared by one byte", {63'd0, fail}, 64'd0);
    chk("R10 only seconds written", snap, mk(8'h30,8'h00,8'h80,8'h01,8'h01,8'h00,3'd0,8'h20));
    step_sec(1);
    chk("R9 counting resumes", snap, mk(8'h31,8'h00,8'h80,8'h01,8'h01,8'h00,3'd0,8'h20));
  endtask

  task automatic t_prescale;
    do_load(8'hFF, mk(8'h10,8'h05,8'h94,8'h15,8'h06,8'h25,3'd3,8'h20));
    wait_cyc(TPS - 1);
    chk("R2 no step before full period", snap, mk(8'h10,8'h05,8'h94,8'h15,8'h06,8'h25,3'd3,8'h20));
    chk("R2 tick high before step edge", {63'd0, tick_o}, 64'd1);
    wait_cyc(1);
    chk("R2 step after full period", snap, mk(8'h11,8'h05,8'h94,8'h15,8'h06,8'h25,3'd3,8'h20));
    chk("R2 tick low after step", {63'd0, tick_o}, 64'd0);
    do_load(8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R10 empty load no effect", snap, mk(8'h11,8'h05,8'h94,8'h15,8'h06,8'h25,3'd3,8'h20));
    wait_cyc(TPS - 1);
    chk("R10 empty load keeps prescaler", snap, mk(8'h12,8'h05,8'h94,8'h15,8'h06,8'h25,3'd3,8'h20));
  endtask

  task automatic t_load_vs_tick;
    wait_cyc(TPS - 1);
    do_load(8'hFF, mk(8'h40,8'h20,8'h81,8'h02,8'h03,8'h04,3'd1,8'h19));
    chk("R11 load wins over tick", snap, mk(8'h40,8'h20,8'h81,8'h02,8'h03,8'h04,3'd1,8'h19));
    step_sec(1);
    chk("R11 next step after load", snap, mk(8'h41,8'h20,8'h81,8'h02,8'h03,8'h04,3'd1,8'h19));
  endtask

  task automatic t_century_carry;
    do_load(8'hFF, mk(8'h58,8'h59,8'hA3,8'h31,8'h12,8'h99,3'd6,8'h19));
    chk("R8 century 19 stored", snap, mk(8'h58,8'h59,8'hA3,8'h31,8'h12,8'h99,3'd6,8'h19));
    step_sec(1);
    chk("R3 seconds to 59", snap, mk(8'h59,8'h59,8'hA3,8'h31,8'h12,8'h99,3'd6,8'h19));
    step_sec(1);
    chk("R3 R4 R6 R7 R8 full carry", snap, mk(8'h00,8'h00,8'h80,8'h01,8'h01,8'h00,3'd0,8'h20));
  endtask

  task automatic t_twelve_hour;
    do_load(8'hFF, mk(8'h59,8'h59,8'h11,8'h10,8'h07,8'h30,3'd4,8'h20));
    step_sec(1);
    chk("R5 11AM to 12PM", snap, mk(8'h00,8'h00,8'h32,8'h10,8'h07,8'h30,3'd4,8'h20));
    do_load(8'hFF, mk(8'h59,8'h59,8'h31,8'h05,8'h07,8'h30,3'd2,8'h20));
    step_sec(1);
    chk("R5 11PM to 12AM next day", snap, mk(8'h00,8'h00,8'h12,8'h06,8'h07,8'h30,3'd3,8'h20));
    do_load(8'hFF, mk(8'h59,8'h59,8'h32,8'h05,8'h07,8'h30,3'd2,8'h20));
    step_sec(1);
    chk("R5 12PM to 1PM", snap, mk(8'h00,8'h00,8'h21,8'h05,8'h07,8'h30,3'd2,8'h20));
    do_load(8'hFF, mk(8'h59,8'h59,8'h12,8'h05,8'h07,8'h30,3'd2,8'h20));
    step_sec(1);
    chk("R5 12AM to 1AM", snap, mk(8'h00,8'h00,8'h01,8'h05,8'h07,8'h30,3'd2,8'h20));
  endtask

  task automatic t_months;
    do_load(8'hFF, mk(8'h59,8'h59,8'hA3,8'h28,8'h02,8'h24,3'd0,8'h20));
    step_sec(1);
    chk("R6 leap Feb 28 to 29", snap, mk(8'h00,8'h00,8'h80,8'h29,8'h02,8'h24,3'd1,8'h20));
    do_load(8'hFF, mk(8'h59,8'h59,8'hA3,8'h29,8'h02,8'h24,3'd1,8'h20));
    step_sec(1);
    chk("R6 leap Feb 29 to Mar 1", snap, mk(8'h00,8'h00,8'h80,8'h01,8'h03,8'h24,3'd2,8'h20));
    do_load(8'hFF, mk(8'h59,8'h59,8'hA3,8'h28,8'h02,8'h23,3'd5,8'h20));
    step_sec(1);
    chk("R6 plain Feb 28 to Mar 1", snap, mk(8'h00,8'h00,8'h80,8'h01,8'h03,8'h23,3'd6,8'h20));
    do_load(8'hFF, mk(8'h59,8'h59,8'hA3,8'h28,8'h02,8'h00,3'd6,8'h20));
    step_sec(1);
    chk("R6 R7 year 00 leap", snap, mk(8'h00,8'h00,8'h80,8'h29,8'h02,8'h00,3'd0,8'h20));
    do_load(8'hFF, mk(8'h59,8'h59,8'hA3,8'h29,8'h04,8'h25,3'd1,8'h20));
    step_sec(1);
    chk("R6 Apr 29 to 30", snap, mk(8'h00,8'h00,8'h80,8'h30,8'h04,8'h25,3'd2,8'h20));
    do_load(8'hFF, mk(8'h59,8'h59,8'hA3,8'h30,8'h04,8'h25,3'd2,8'h20));
    step_sec(1);
    chk("R6 Apr 30 to May 1", snap, mk(8'h00,8'h00,8'h80,8'h01,8'h05,8'h25,3'd3,8'h20));
  endtask

  task automatic t_load_fields;
    do_load(8'hFF, {8'h55, 8'h07, 8'h42, 8'hE9, 8'hD7, 8'hC5, 8'h83, 8'hA5});
    chk("R7 R8 R10 load cleanup", snap, mk(8'h25,8'h03,8'h85,8'h17,8'h09,8'h42,3'd0,8'h20));
    do_load(8'h04, {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h33, 8'hFF, 8'hFF});
    chk("R10 hour byte only", snap, mk(8'h25,8'h03,8'h33,8'h17,8'h09,8'h42,3'd0,8'h20));
  endtask

  initial begin
    rst_n = 1'b0; osc_en = 1'b1; ld_stb = 1'b0; ld_be = '0; ld_img = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset_and_fail();
    t_prescale();
    t_load_vs_tick();
    t_century_carry();
    t_twelve_hour();
    t_months();
    t_load_fields();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule